// File: doc/BRIEF.md
# Single Zero-Run Validator and Counter

This block looks at one input word and decides, with no clock and no stored state, whether the zero bits in that word form a single unbroken group. If they do, it reports how many zeros are in that group. If the zeros are split into two or more groups, it raises an error flag and forces the count to zero.

A word with no zeros at all counts as legal and reports a count of zero. Zero groups do not wrap around the ends of the word. Zeros at the top bit and zeros at the bottom bit, with ones between them, are two separate groups.

The block is meant to sit between registers in a single-cycle datapath. Both outputs depend only on the present input, so a result settles within the same clock period as its operand. There is no data stream and no handshake at this boundary, so every pin is a plain level signal.

Top module: `zero_run_check`

## Requirements
- R1: An all-ones word (0xFF) is legal: `run_err` is 0 and `zero_count` is 0.
- R2: An all-zeros word (0x00) is legal: `run_err` is 0 and `zero_count` is 8.
- R3: A word whose zeros form exactly one contiguous group gives `run_err` = 0 and a `zero_count` equal to the length of that group. For example, 8'b11000111 gives 3.
- R4: A word whose zeros form two or more separate groups gives `run_err` = 1. For example, 8'b00111100 and 8'b10101111 are both flagged.
- R5: Whenever `run_err` is 1, `zero_count` is 0.
- R6: Groups do not wrap around the word's ends. 8'b01111110 holds two groups, so it is flagged with `run_err` = 1 and a count of 0.
- R7: `zero_count` is 4 bits wide, is unsigned binary, and never exceeds 8.
- R8: The outputs are purely combinational. A change on `word_in` shows up on both outputs within the same clock period, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_in | input | 8 | Word under test; bit 7 is the MSB |
| zero_count | output | 4 | Length of the single zero group; 0 when the word is illegal or all ones |
| run_err | output | 1 | Active-high flag: the word has two or more separate zero groups |

## Verification
The bench builds the block with the default width of 8 bits. At that width the input space holds only 256 words, so every word is applied in turn. This covers every placement and length of a single group, and every split pattern including the end-to-end case. Seeded random words and a few directed corner words are then applied between clock edges, to check that the outputs follow the input within one period.

// File: rtl/zero_run_pkg.sv
package zero_run_pkg;
  // Default word width of the validator
  localparam int unsigned ZR_WIDTH_DEF = 8;

  // Width needed to hold a count from 0 to W inclusive
  function automatic int unsigned zr_cnt_bits(input int unsigned w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/zero_run_edge_scan.sv
// Marks every bit where a zero group begins, scanning from the MSB down.
// A virtual one sits above the MSB, so a zero at the top starts a group.
module zero_run_edge_scan #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH:0] ext;

  assign ext = {1'b1, word};

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_fall
      assign fall[gi] = ext[gi+1] & ~ext[gi];
    end
  endgenerate
endmodule

// File: rtl/zero_run_multi_detect.sv
// Flags when more than one group-start marker is set.
module zero_run_multi_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] fall,
  output logic             multi
);
  logic [WIDTH:0] seen_above;
  logic [WIDTH-1:0] clash;

  assign seen_above[WIDTH] = 1'b0;

  genvar gi;
  generate
    for (gi = WIDTH - 1; gi >= 0; gi--) begin : g_chain
      assign clash[gi]      = fall[gi] & seen_above[gi+1];
      assign seen_above[gi] = seen_above[gi+1] | fall[gi];
    end
  endgenerate

  assign multi = |clash;
endmodule

// File: rtl/zero_run_len_count.sv
// Counts the zero bits of the word. When the zeros form a single group,
// this equals the length of that group.
module zero_run_len_count #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CNT_W = zero_run_pkg::zr_cnt_bits(WIDTH)
) (
  input  logic [WIDTH-1:0] word,
  output logic [CNT_W-1:0] zeros
);
  always_comb begin
    zeros = '0;
    for (int i = 0; i < WIDTH; i++) begin
      zeros = zeros + {{(CNT_W-1){1'b0}}, ~word[i]};
    end
  end
endmodule

// File: rtl/zero_run_check.sv
// Single zero-run validator: legality flag plus run length, fully combinational.
module zero_run_check #(
  parameter int unsigned WIDTH = zero_run_pkg::ZR_WIDTH_DEF,
  localparam int unsigned CNT_W = zero_run_pkg::zr_cnt_bits(WIDTH)
) (
  input  logic [WIDTH-1:0] word_in,
  output logic [CNT_W-1:0] zero_count,
  output logic             run_err
);
  logic [WIDTH-1:0] fall_mark;
  logic             split_word;
  logic [CNT_W-1:0] raw_zeros;

  zero_run_edge_scan #(.WIDTH(WIDTH)) u_scan (
    .word (word_in),
    .fall (fall_mark)
  );

  zero_run_multi_detect #(.WIDTH(WIDTH)) u_multi (
    .fall  (fall_mark),
    .multi (split_word)
  );

  zero_run_len_count #(.WIDTH(WIDTH)) u_len (
    .word  (word_in),
    .zeros (raw_zeros)
  );

  assign run_err    = split_word;
  assign zero_count = split_word ? '0 : raw_zeros;
endmodule

// File: rtl/zero_run_check_sva.sv
module zero_run_check_sva #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CNT_W = zero_run_pkg::zr_cnt_bits(WIDTH)
) (
  input logic [WIDTH-1:0] word_in,
  input logic [CNT_W-1:0] zero_count,
  input logic             run_err
);
  always_comb begin
    // R1: no zeros means legal, count zero
    if (&word_in) begin
      assert_all_ones_R1: assert (!run_err && zero_count == '0);
    end
    // R2: all zeros means legal, full count
    if (word_in == '0) begin
      assert_all_zeros_R2: assert (!run_err && zero_count == CNT_W'(WIDTH));
    end
    // R3: legal words report every zero as part of the one group
    if (!run_err) begin
      assert_legal_len_R3: assert (zero_count == CNT_W'($countones(~word_in)));
    end
    // R5: error forces count to zero
    if (run_err) begin
      assert_err_zero_R5: assert (zero_count == '0);
    end
    // R6: zeros at both ends with a one between are two groups
    if (!word_in[WIDTH-1] && !word_in[0] && (|word_in)) begin
      assert_no_wrap_R6: assert (run_err);
    end
    // R7: count stays within range
    assert_count_range_R7: assert (zero_count <= CNT_W'(WIDTH));
  end
endmodule

bind zero_run_check zero_run_check_sva #(.WIDTH(WIDTH)) u_sva (
  .word_in    (word_in),
  .zero_count (zero_count),
  .run_err    (run_err)
);

// File: tb/sim_zero_run_check.sv
`timescale 1ns/1ps
module sim_zero_run_check;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] word_in;
  logic [3:0] zero_count;
  logic       run_err;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  zero_run_check u0 (
    .word_in    (word_in),
    .zero_count (zero_count),
    .run_err    (run_err)
  );

  // Reference: count groups and total zeros by a plain scan from the MSB
  function automatic int ref_groups(input logic [7:0] w);
    int g = 0;
    logic prev = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      if (prev && !w[i]) g++;
      prev = w[i];
    end
    return g;
  endfunction

  function automatic int ref_zeros(input logic [7:0] w);
    int z = 0;
    for (int i = 0; i < 8; i++) if (!w[i]) z++;
    return z;
  endfunction

  function automatic string req_of(input logic [7:0] w);
    int g = ref_groups(w);
    if (w == 8'hFF) return "R1";
    if (w == 8'h00) return "R2";
    if (g >= 2 && !w[7] && !w[0]) return "R6";
    if (g >= 2) return "R4/R5";
    return "R3";
  endfunction

  task automatic check_word(input logic [7:0] w);
    int g;
    logic [3:0] exp_cnt;
    logic exp_err;
    g = ref_groups(w);
    exp_err = (g >= 2);
    exp_cnt = exp_err ? 4'd0 : 4'(ref_zeros(w));
    @(negedge clk);
    word_in = w;
    #1;
    total++;
    if (run_err !== exp_err || zero_count !== exp_cnt) begin
      bad++;
      $display("FAIL %s word=%b got cnt=%0d err=%0b exp cnt=%0d err=%0b",
               req_of(w), w, zero_count, run_err, exp_cnt, exp_err);
    end
    total++;
    if (zero_count > 4'd8) begin // R7
      bad++;
      $display("FAIL R7 word=%b got cnt=%0d exp <=8", w, zero_count);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    logic [7:0] rw;
    word_in = 8'hFF;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state check with the idle all-ones word, R1
    @(negedge clk);
    total++;
    if (zero_count !== 4'd0 || run_err !== 1'b0) begin
      bad++;
      $display("FAIL R1 idle got cnt=%0d err=%0b exp cnt=0 err=0", zero_count, run_err);
    end
    // directed corners: R1 R2 R3 R4 R6
    check_word(8'hFF);
    check_word(8'h00);
    check_word(8'b11000111);
    check_word(8'b00111100);
    check_word(8'b10101111);
    check_word(8'b01111110);
    check_word(8'b01111111);
    check_word(8'b11111110);
    // R8: two words inside one period, no edge between
    @(negedge clk);
    word_in = 8'b11100111;
    #1;
    total++;
    if (zero_count !== 4'd2 || run_err !== 1'b0) begin
      bad++;
      $display("FAIL R8 first got cnt=%0d err=%0b exp cnt=2 err=0", zero_count, run_err);
    end
    word_in = 8'b01100110;
    #1;
    total++;
    if (zero_count !== 4'd0 || run_err !== 1'b1) begin
      bad++;
      $display("FAIL R8 second got cnt=%0d err=%0b exp cnt=0 err=1", zero_count, run_err);
    end
    // exhaustive sweep of all words
    for (int v = 0; v < 256; v++) check_word(8'(v));
    // seeded random words
    seed = 32'd1234;
    rw = 8'($urandom(seed));
    for (int k = 0; k < 300; k++) begin
      rw = 8'($urandom);
      check_word(rw);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule